// File: doc/BRIEF.md
# Windowed Deadman Timer

A bus-mapped deadman timer. Once software sets the enable bit, the timer counts one clock cycle at a time. Software must restart it before the count reaches a programmed period. A restart takes two writes. The first write arms the timer with a key to the arming register. The second write sends a key to the restart register, and it is honoured only while the restart window is open. The window is the last stretch of the period, and its length is set by the window interval register. If the count reaches the period, the timer raises a one-cycle timeout pulse, sets a sticky event flag and sets a separate cause flag, and then starts counting again from zero. The cause flag survives disabling, so that software can later tell why a reset happened.

Each restart step has its own error flag. Both error flags stay set until the timer is disabled. Software polls the window-open status bit before it sends the second key. For the one cycle after the enable bit drops, the block ignores all bus access.

Top module: `deadman_timer`

## Requirements
- R1: After reset, these registers read zero: control (0x00), count (0x40), status (0x30) and cause (0x80). The period (0x60) and window (0x70) registers read their parameter defaults, and `timeout_o` is low.
- R2: Control bit 15 is the enable. A write to 0x00 loads it. A write to 0x08 sets it where wdata bit 15 is one. A write to 0x04 clears it where wdata bit 15 is one. While enabled, the count rises by one every cycle. While disabled, it returns to zero.
- R3: Status bit 0 is high while the timer is enabled and count + window >= period.
- R4: A write to 0x10 with wdata[15:8] = 0x40 arms the restart. A write there with any other value disarms and sets status bit 7.
- R5: A write to 0x20 with wdata[7:0] = 0x08, while armed and with the window open, sets the count to zero and disarms.
- R6: A write to 0x20 while not armed sets status bit 7. While armed, a write with a wrong value or with the window closed sets status bit 6 and disarms. In neither case does the count restart.
- R7: When count + 1 reaches the period, the count returns to zero. In the same step, `timeout_o` goes high for exactly one cycle and status bit 5 is set.
- R8: Cause register bit 5 is set on every timeout. It stays set through disable. Writing a one to bit 5 at 0x80 clears it, but a timeout in the same cycle wins.
- R9: Disabling the timer clears status bits 7, 6 and 5 and the armed state.
- R10: In the cycle right after the enable bit falls, writes are ignored and reads return zero.
- R11: The period and window registers accept writes only while the timer is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| timeout_o | output | 1 | One-cycle pulse when the period expires |
| cause_o | output | 1 | Sticky timeout cause flag |

## Verification
Almost every fault in the internal state becomes visible in the count or status read within a cycle of the write that exposes it. A lost armed state shows up on the next restart key, because bit 7 sets and the count does not return to zero. A window comparison that is off by one changes status bit 0 at the boundary count. A fault in the timeout path moves the `timeout_o` pulse away from exactly period edges after enable. A missing lockout lets the ignored enable write take effect, which the control read shows on the next cycle.

// File: rtl/deadman_pkg.sv
package deadman_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_CTRL     = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_CTRL_CLR = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_CTRL_SET = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_ARM      = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_KICK     = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_STAT     = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_COUNT    = 8'h40;
  localparam logic [ADDR_W-1:0] OFF_PERIOD   = 8'h60;
  localparam logic [ADDR_W-1:0] OFF_WINDOW   = 8'h70;
  localparam logic [ADDR_W-1:0] OFF_CAUSE    = 8'h80;

  localparam logic [7:0] ARM_KEY  = 8'h40;
  localparam logic [7:0] KICK_KEY = 8'h08;

  localparam int unsigned EN_BIT    = 15;
  localparam int unsigned CAUSE_BIT = 5;
endpackage

// File: rtl/dt_counter.sv
module dt_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             restart,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] window,
  output logic [CNT_W-1:0] count,
  output logic             win_open,
  output logic             hit
);
  logic [CNT_W-1:0] count_q, count_d;
  logic [CNT_W:0]   inc_ext;
  logic [CNT_W:0]   win_sum;

  always_comb begin
    inc_ext  = {1'b0, count_q} + {{CNT_W{1'b0}}, 1'b1};
    win_sum  = {1'b0, count_q} + {1'b0, window};
    hit      = en && (inc_ext >= {1'b0, period});
    win_open = en && (win_sum >= {1'b0, period});
    if (!en || restart || hit) count_d = '0;
    else                       count_d = inc_ext[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assign count = count_q;
endmodule

// File: rtl/dt_keyseq.sv
module dt_keyseq (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic wr_arm,
  input  logic arm_ok,
  input  logic wr_kick,
  input  logic kick_ok,
  input  logic win_open,
  output logic restart,
  output logic armed,
  output logic bad_arm,
  output logic bad_kick
);
  logic armed_q, armed_d;
  logic bad_arm_q, bad_arm_d;
  logic bad_kick_q, bad_kick_d;

  always_comb begin
    armed_d    = armed_q;
    bad_arm_d  = bad_arm_q;
    bad_kick_d = bad_kick_q;
    restart    = 1'b0;
    if (!en) begin
      armed_d    = 1'b0;
      bad_arm_d  = 1'b0;
      bad_kick_d = 1'b0;
    end else if (wr_arm) begin
      armed_d = arm_ok;
      if (!arm_ok) bad_arm_d = 1'b1;
    end else if (wr_kick) begin
      armed_d = 1'b0;
      if (!armed_q)                  bad_arm_d  = 1'b1;
      else if (kick_ok && win_open)  restart    = 1'b1;
      else                           bad_kick_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q    <= 1'b0;
      bad_arm_q  <= 1'b0;
      bad_kick_q <= 1'b0;
    end else begin
      armed_q    <= armed_d;
      bad_arm_q  <= bad_arm_d;
      bad_kick_q <= bad_kick_d;
    end
  end

  assign armed    = armed_q;
  assign bad_arm  = bad_arm_q;
  assign bad_kick = bad_kick_q;
endmodule

// File: rtl/deadman_timer.sv
module deadman_timer
  import deadman_pkg::*;
#(
  parameter int unsigned CNT_W      = 24,
  parameter int unsigned PERIOD_RST = 64,
  parameter int unsigned WINDOW_RST = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              timeout_o,
  output logic              cause_o
);
  localparam logic [CNT_W-1:0] PER_INIT = CNT_W'(PERIOD_RST);
  localparam logic [CNT_W-1:0] WIN_INIT = CNT_W'(WINDOW_RST);

  logic en_q, en_d, lock_q, lock_d;
  logic evt_q, evt_d, cause_q, cause_d, tmo_q;
  logic [CNT_W-1:0] period_q, period_d, window_q, window_d;
  logic [CNT_W-1:0] count;
  logic wr, wr_arm, wr_kick;
  logic win_open, hit, restart, armed, bad_arm, bad_kick;

  assign wr      = bus_we && !lock_q;
  assign wr_arm  = wr && (bus_addr == OFF_ARM);
  assign wr_kick = wr && (bus_addr == OFF_KICK);

  dt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .en(en_q), .restart(restart),
    .period(period_q), .window(window_q),
    .count(count), .win_open(win_open), .hit(hit)
  );

  dt_keyseq u_keyseq (
    .clk(clk), .rst_n(rst_n), .en(en_q),
    .wr_arm(wr_arm), .arm_ok(bus_wdata[15:8] == ARM_KEY),
    .wr_kick(wr_kick), .kick_ok(bus_wdata[7:0] == KICK_KEY),
    .win_open(win_open), .restart(restart), .armed(armed),
    .bad_arm(bad_arm), .bad_kick(bad_kick)
  );

  always_comb begin
    en_d     = en_q;
    period_d = period_q;
    window_d = window_q;
    if (wr) begin
      case (bus_addr)
        OFF_CTRL:     en_d = bus_wdata[EN_BIT];
        OFF_CTRL_SET: if (bus_wdata[EN_BIT]) en_d = 1'b1;
        OFF_CTRL_CLR: if (bus_wdata[EN_BIT]) en_d = 1'b0;
        OFF_PERIOD:   if (!en_q) period_d = bus_wdata[CNT_W-1:0];
        OFF_WINDOW:   if (!en_q) window_d = bus_wdata[CNT_W-1:0];
        default: ;
      endcase
    end
    lock_d  = en_q && !en_d;
    evt_d   = en_q && (evt_q || hit);
    cause_d = hit || (cause_q &&
              !(wr && bus_addr == OFF_CAUSE && bus_wdata[CAUSE_BIT]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      lock_q   <= 1'b0;
      evt_q    <= 1'b0;
      cause_q  <= 1'b0;
      tmo_q    <= 1'b0;
      period_q <= PER_INIT;
      window_q <= WIN_INIT;
    end else begin
      en_q     <= en_d;
      lock_q   <= lock_d;
      evt_q    <= evt_d;
      cause_q  <= cause_d;
      tmo_q    <= hit;
      period_q <= period_d;
      window_q <= window_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (!lock_q) begin
      case (bus_addr)
        OFF_CTRL:   bus_rdata[EN_BIT] = en_q;
        OFF_STAT:   bus_rdata[7:0] = {bad_arm, bad_kick, evt_q, 4'b0000, win_open};
        OFF_COUNT:  bus_rdata = DATA_W'(count);
        OFF_PERIOD: bus_rdata = DATA_W'(period_q);
        OFF_WINDOW: bus_rdata = DATA_W'(window_q);
        OFF_CAUSE:  bus_rdata[CAUSE_BIT] = cause_q;
        default: ;
      endcase
    end
  end

  assign timeout_o = tmo_q;
  assign cause_o   = cause_q;
endmodule

// File: rtl/deadman_timer_chk.sv
module deadman_timer_chk #(
  parameter int unsigned CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_q,
  input logic             lock_q,
  input logic [CNT_W-1:0] count,
  input logic             win_open,
  input logic             restart,
  input logic             armed,
  input logic             bad_arm,
  input logic             evt_q,
  input logic             cause_q,
  input logic             timeout_o
);
  assert_idle_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !lock_q) |-> (count == '0));

  assert_window_needs_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
    win_open |-> en_q);

  assert_restart_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (count == '0 && !armed));

  assert_bad_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && bad_arm) |=> (bad_arm || !en_q));

  assert_timeout_effects_R7: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> (count == '0 && cause_q && (evt_q || !en_q)));

  assert_cause_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cause_q) |-> timeout_o);

  assert_lock_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(en_q));
endmodule

bind deadman_timer deadman_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .lock_q(lock_q), .count(count),
  .win_open(win_open), .restart(restart), .armed(armed), .bad_arm(bad_arm),
  .evt_q(evt_q), .cause_q(cause_q), .timeout_o(timeout_o)
);

// File: tb/deadman_timer_bench.sv
module deadman_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 42;
  // entry: req[77:74] kind[73:72] (0 write, 1 read, 2 idle) addr[71:64] data[63:32] exp[31:0]
  localparam logic [77:0] VEC [NV] = '{
    {4'd11, 2'd0, 8'h60, 32'd20,     32'd0},     // R11 period while disabled
    {4'd11, 2'd0, 8'h70, 32'd5,      32'd0},
    {4'd11, 2'd1, 8'h60, 32'd0,      32'd20},
    {4'd11, 2'd1, 8'h70, 32'd0,      32'd5},
    {4'd2,  2'd0, 8'h08, 32'h8000,   32'd0},     // R2 set alias
    {4'd2,  2'd1, 8'h00, 32'd0,      32'h8000},
    {4'd2,  2'd1, 8'h40, 32'd0,      32'd0},
    {4'd2,  2'd2, 8'h00, 32'd3,      32'd0},
    {4'd2,  2'd1, 8'h40, 32'd0,      32'd3},
    {4'd3,  2'd1, 8'h30, 32'd0,      32'd0},     // R3 closed
    {4'd4,  2'd0, 8'h10, 32'h4000,   32'd0},     // R4 arm
    {4'd3,  2'd2, 8'h00, 32'd11,     32'd0},
    {4'd3,  2'd1, 8'h30, 32'd0,      32'd1},     // R3 open at boundary
    {4'd5,  2'd0, 8'h20, 32'h08,     32'd0},     // R5 restart
    {4'd5,  2'd1, 8'h40, 32'd0,      32'd0},
    {4'd5,  2'd1, 8'h30, 32'd0,      32'd0},
    {4'd6,  2'd0, 8'h20, 32'h08,     32'd0},     // R6 kick unarmed
    {4'd6,  2'd1, 8'h30, 32'd0,      32'h80},
    {4'd10, 2'd0, 8'h04, 32'h8000,   32'd0},     // R2 clear alias, R10 lock
    {4'd10, 2'd1, 8'h30, 32'd0,      32'd0},
    {4'd10, 2'd1, 8'h40, 32'd0,      32'd0},
    {4'd10, 2'd0, 8'h00, 32'h8000,   32'd0},     // R10 ignored
    {4'd10, 2'd1, 8'h00, 32'd0,      32'd0},
    {4'd9,  2'd1, 8'h30, 32'd0,      32'd0},     // R9 flags cleared
    {4'd2,  2'd1, 8'h40, 32'd0,      32'd0},
    {4'd2,  2'd0, 8'h00, 32'h8000,   32'd0},
    {4'd4,  2'd0, 8'h10, 32'h4000,   32'd0},
    {4'd6,  2'd0, 8'h20, 32'h08,     32'd0},     // R6 window closed
    {4'd6,  2'd1, 8'h30, 32'd0,      32'h40},
    {4'd6,  2'd1, 8'h40, 32'd0,      32'd2},
    {4'd4,  2'd0, 8'h10, 32'h1200,   32'd0},     // R4 wrong arm key
    {4'd4,  2'd1, 8'h30, 32'd0,      32'hC0},
    {4'd7,  2'd2, 8'h00, 32'd16,     32'd0},
    {4'd8,  2'd1, 8'h80, 32'd0,      32'd0},
    {4'd7,  2'd2, 8'h00, 32'd1,      32'd0},
    {4'd7,  2'd1, 8'h30, 32'd0,      32'hE0},    // R7 event
    {4'd8,  2'd1, 8'h80, 32'd0,      32'h20},
    {4'd7,  2'd1, 8'h40, 32'd0,      32'd0},
    {4'd8,  2'd0, 8'h80, 32'h20,     32'd0},     // R8 clear cause
    {4'd8,  2'd1, 8'h80, 32'd0,      32'd0},
    {4'd11, 2'd0, 8'h60, 32'd99,     32'd0},     // R11 ignored when enabled
    {4'd11, 2'd1, 8'h60, 32'd0,      32'd20}
  };

  logic        clk, rst_n, bus_we, timeout_o, cause_o;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  int errors = 0;
  int checks = 0;

  deadman_timer u_deadman_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .timeout_o(timeout_o), .cause_o(cause_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd("R1", 8'h00, 32'd0);
    rd("R1", 8'h30, 32'd0);
    rd("R1", 8'h40, 32'd0);
    rd("R1", 8'h80, 32'd0);
    rd("R1", 8'h60, 32'd64);
    rd("R1", 8'h70, 32'd16);
    check("R1", {31'd0, timeout_o}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VEC[i][77:74]);
      case (VEC[i][73:72])
        2'd0: wr(VEC[i][71:64], VEC[i][63:32]);
        2'd1: rd(tag, VEC[i][71:64], VEC[i][31:0]);
        default: idle(int'(VEC[i][63:32]));
      endcase
    end

    // R7 timeout pulse timing with period 8
    wr(8'h04, 32'h8000);
    idle(1);
    wr(8'h60, 32'd8);
    wr(8'h70, 32'd2);
    wr(8'h00, 32'h8000);
    idle(7);
    check("R7", {31'd0, timeout_o}, 32'd0);
    idle(1);
    check("R7", {31'd0, timeout_o}, 32'd1);
    check("R8", {31'd0, cause_o}, 32'd1);
    idle(1);
    check("R7", {31'd0, timeout_o}, 32'd0);

    // R8 cause survives disable, R9 status cleared
    wr(8'h04, 32'h8000);
    idle(1);
    rd("R8", 8'h80, 32'h20);
    rd("R9", 8'h30, 32'd0);

    // R6 wrong kick value inside window
    wr(8'h00, 32'h8000);
    wr(8'h10, 32'h4000);
    idle(5);
    wr(8'h20, 32'h09);
    rd("R6", 8'h30, 32'h41);
    rd("R6", 8'h40, 32'd7);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule